// File: doc/BRIEF.md
# Addressed Serial LED Command Decoder

This block takes a two-wire serial stream, made of a data line and a clock line, and turns it into write strobes for the brightness register file of a 24-channel dimming controller. The stream is divided into bytes. Each packet opens with a start byte, then gives a device address, then gives channel selectors, each followed by a brightness byte. A period byte closes the packet. When the address names this device, or names every device, the block sends each brightness value out as a one-cycle write strobe. The strobe carries a channel index and a 7-bit duty value. When the period byte arrives, the block sends a one-cycle commit pulse. The downstream register file uses that pulse to copy its staged values to the live outputs.

The block runs in a single system clock domain. The serial clock and data lines are synchronised. Serial clock edges are found by oversampling, so the system clock must run at least four times faster than the serial clock. A channel selector can address a single channel or all channels. It can also enter a sequential mode, in which the brightness bytes that follow fill channels 0, 1, 2 and onward. Bytes sent while no matching packet is open are dropped.

Top module: `led_cmd_decoder`

## Requirements
- R1: Each serial data bit is sampled on a rising serial-clock edge, most significant bit first. A byte takes effect only after the falling edge of its eighth serial clock, never at the eighth rising edge.
- R2: The byte 0xFF starts a new packet from any state, including in the middle of a packet. Bytes received before any 0xFF produce no strobe and no commit.
- R3: The byte after 0xFF is the address. It matches when bit 7 is 0, bit 0 is 0 and bits 6:1 equal `local_id`. Any byte with bit 7 at 0 and bit 0 at 1 matches every device. If the address does not match, every byte up to the next 0xFF is ignored.
- R4: A channel selector is an even code (n+1)*2 for channel n from 0 to 23, covering 0x02 to 0x30. The data byte that follows produces one strobe with `wr_chan` = n and `wr_duty` = data bits 7:1, with `wr_all` low.
- R5: A single matched packet may hold several selector/data pairs. Each pair produces its own strobe, in the order the pairs arrive.
- R6: The selector 0x40 makes the next data byte produce one strobe with `wr_all` high, which writes that duty to every channel.
- R7: The selector 0x60 enters sequential mode. The k-th data byte that follows goes to channel k-1, counting from 0. Bytes after the 24th produce no strobe. Channels that are not reached keep their previous value.
- R8: Inside sequential mode, codes such as 0x40 and 0x02 are treated as data and not as selectors. Only 0xFF restarts the packet, and 0x81 still commits.
- R9: The byte 0x81, received in a matched packet after the address, produces one commit pulse and closes the packet. Packets that do not match never commit.
- R10: The active-high `rst` clears the bit counter, the packet state and the address match. After reset, no strobe or commit is issued until a new 0xFF and a matching address arrive.
- R11: `wr_valid` and `commit` are one-cycle pulses, and the two are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst | input | 1 | Active-high synchronous reset |
| ser_clk | input | 1 | Serial clock line, asynchronous |
| ser_dat | input | 1 | Serial data line, asynchronous |
| local_id | input | 6 | Device identity compared with address bits 6:1 |
| wr_valid | output | 1 | One-cycle brightness write strobe |
| wr_all | output | 1 | With wr_valid: the write targets every channel |
| wr_chan | output | 5 | Channel index of the write, 0 to 23 |
| wr_duty | output | 7 | Duty value of the write, 0 (off) to 127 (fully on) |
| commit | output | 1 | One-cycle pulse when a matched packet ends with its period byte |

## Verification
A table of single-pair packets sends its bytes to both ends of the channel code range and to a middle code. It uses the exact address and also two different all-select addresses. It covers the all-channel selector and the duty values 0 and 127. Each entry would expose a wrong bit order, an off-by-one in the channel index, or an all-select decode that is too narrow. Directed packets then check five cases:
- A strobe is held back until the eighth falling edge.
- Stray bytes before any start byte are dropped.
- A packet with the wrong address is silently ignored.
- A 0xFF in the middle of a packet restarts the packet.
- Sequential mode stops at the channel limit, treats selector-like codes as data, and leaves channels it did not reach unchanged.

A reset in the middle of a packet has to drop the half-finished packet.

// File: rtl/led_cmd_pkg.sv
package led_cmd_pkg;

    typedef enum logic [2:0] {
        ST_WAIT,    // no packet open, or packet not for us
        ST_ADDR,    // next byte is the address
        ST_SUB,     // next byte is a channel selector or the period byte
        ST_DATA,    // next byte is the brightness for the chosen target
        ST_SEQ      // sequential fill of channels
    } dec_state_e;

    localparam logic [7:0] BYTE_START  = 8'hFF;
    localparam logic [7:0] BYTE_COMMIT = 8'h81;
    localparam logic [7:0] SEL_ALL     = 8'h40;
    localparam logic [7:0] SEL_SEQ     = 8'h60;

endpackage

// File: rtl/ser_edge_sync.sv
module ser_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ser_clk,
    input  logic ser_dat,
    output logic dat_s,
    output logic clk_rise,
    output logic clk_fall
);
    typedef struct packed {
        logic [STAGES-1:0] ck_pipe;
        logic [STAGES-1:0] dt_pipe;
        logic              ck_prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.ck_pipe = {s_q.ck_pipe[STAGES-2:0], ser_clk};
        s_d.dt_pipe = {s_q.dt_pipe[STAGES-2:0], ser_dat};
        s_d.ck_prev = s_q.ck_pipe[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign dat_s    = s_q.dt_pipe[STAGES-1];
    assign clk_rise =  s_q.ck_pipe[STAGES-1] & ~s_q.ck_prev;
    assign clk_fall = ~s_q.ck_pipe[STAGES-1] &  s_q.ck_prev;
endmodule

// File: rtl/ser_byte_shift.sv
module ser_byte_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dat_s,
    input  logic              clk_rise,
    input  logic              clk_fall,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_val
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              vld;
        logic [BYTE_W-1:0] out;
    } shift_t;

    shift_t b_d, b_q;

    always_comb begin
        b_d     = b_q;
        b_d.vld = 1'b0;
        if (clk_rise) begin
            b_d.sh  = {b_q.sh[BYTE_W-2:0], dat_s};
            b_d.cnt = b_q.cnt + CNT_W'(1);
        end else if (clk_fall && b_q.cnt == CNT_W'(BYTE_W)) begin
            b_d.vld = 1'b1;
            b_d.out = b_q.sh;
            b_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) b_q <= '0;
        else     b_q <= b_d;
    end

    assign byte_vld = b_q.vld;
    assign byte_val = b_q.out;
endmodule

// File: rtl/led_pkt_fsm.sv
module led_pkt_fsm
    import led_cmd_pkg::*;
#(
    parameter int NUM_CH = 24,
    parameter int ID_W   = 6,
    parameter int DUTY_W = 7,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int SEQ_W = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_vld,
    input  logic [7:0]        byte_val,
    input  logic [ID_W-1:0]   local_id,
    output logic              wr_valid,
    output logic              wr_all,
    output logic [CH_W-1:0]   wr_chan,
    output logic [DUTY_W-1:0] wr_duty,
    output logic              commit
);
    localparam logic [6:0]       NCH7  = 7'(NUM_CH);
    localparam logic [SEQ_W-1:0] NCHS  = SEQ_W'(NUM_CH);

    typedef struct packed {
        dec_state_e        st;
        logic [CH_W-1:0]   tgt;
        logic              tgt_all;
        logic [SEQ_W-1:0]  idx;
        logic              wr;
        logic              wall;
        logic [CH_W-1:0]   wch;
        logic [DUTY_W-1:0] duty;
        logic              cmt;
    } fsm_t;

    fsm_t f_d, f_q;

    logic       addr_hit;
    logic [6:0] sel_num;
    logic [6:0] sel_idx;
    logic       sel_ok;

    always_comb begin
        addr_hit = ~byte_val[7] & (byte_val[0] | (byte_val[ID_W:1] == local_id));
        sel_num  = byte_val[7:1];
        sel_idx  = sel_num - 7'd1;
        sel_ok   = ~byte_val[0] && sel_num != 7'd0 && sel_num <= NCH7;
    end

    always_comb begin
        f_d      = f_q;
        f_d.wr   = 1'b0;
        f_d.wall = 1'b0;
        f_d.cmt  = 1'b0;
        if (byte_vld) begin
            if (byte_val == BYTE_START) begin
                f_d.st = ST_ADDR;
            end else begin
                unique case (f_q.st)
                    ST_WAIT: f_d.st = ST_WAIT;
                    ST_ADDR: f_d.st = addr_hit ? ST_SUB : ST_WAIT;
                    ST_SUB: begin
                        if (byte_val == BYTE_COMMIT) begin
                            f_d.cmt = 1'b1;
                            f_d.st  = ST_WAIT;
                        end else if (byte_val == SEL_ALL) begin
                            f_d.tgt_all = 1'b1;
                            f_d.st      = ST_DATA;
                        end else if (byte_val == SEL_SEQ) begin
                            f_d.idx = '0;
                            f_d.st  = ST_SEQ;
                        end else if (sel_ok) begin
                            f_d.tgt_all = 1'b0;
                            f_d.tgt     = sel_idx[CH_W-1:0];
                            f_d.st      = ST_DATA;
                        end else begin
                            f_d.st = ST_WAIT;
                        end
                    end
                    ST_DATA: begin
                        if (byte_val == BYTE_COMMIT) begin
                            f_d.cmt = 1'b1;
                            f_d.st  = ST_WAIT;
                        end else begin
                            f_d.wr   = 1'b1;
                            f_d.wall = f_q.tgt_all;
                            f_d.wch  = f_q.tgt_all ? '0 : f_q.tgt;
                            f_d.duty = byte_val[DUTY_W:1];
                            f_d.st   = ST_SUB;
                        end
                    end
                    ST_SEQ: begin
                        if (byte_val == BYTE_COMMIT) begin
                            f_d.cmt = 1'b1;
                            f_d.st  = ST_WAIT;
                        end else if (f_q.idx < NCHS) begin
                            f_d.wr   = 1'b1;
                            f_d.wch  = f_q.idx[CH_W-1:0];
                            f_d.duty = byte_val[DUTY_W:1];
                            f_d.idx  = f_q.idx + SEQ_W'(1);
                        end
                    end
                    default: f_d.st = ST_WAIT;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) f_q <= '{st: ST_WAIT, default: '0};
        else     f_q <= f_d;
    end

    assign wr_valid = f_q.wr;
    assign wr_all   = f_q.wall;
    assign wr_chan  = f_q.wch;
    assign wr_duty  = f_q.duty;
    assign commit   = f_q.cmt;
endmodule

// File: rtl/led_cmd_decoder.sv
module led_cmd_decoder #(
    parameter int NUM_CH      = 24,
    parameter int ID_W        = 6,
    parameter int DUTY_W      = 7,
    parameter int SYNC_STAGES = 2,
    localparam int CH_W       = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic [ID_W-1:0]   local_id,
    output logic              wr_valid,
    output logic              wr_all,
    output logic [CH_W-1:0]   wr_chan,
    output logic [DUTY_W-1:0] wr_duty,
    output logic              commit
);
    logic       dat_s, ck_rise, ck_fall;
    logic       byte_vld;
    logic [7:0] byte_val;

    ser_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .dat_s(dat_s), .clk_rise(ck_rise), .clk_fall(ck_fall)
    );

    ser_byte_shift #(.BYTE_W(8)) u_shift (
        .clk(clk), .rst(rst), .dat_s(dat_s), .clk_rise(ck_rise),
        .clk_fall(ck_fall), .byte_vld(byte_vld), .byte_val(byte_val)
    );

    led_pkt_fsm #(.NUM_CH(NUM_CH), .ID_W(ID_W), .DUTY_W(DUTY_W)) u_fsm (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_val(byte_val),
        .local_id(local_id), .wr_valid(wr_valid), .wr_all(wr_all),
        .wr_chan(wr_chan), .wr_duty(wr_duty), .commit(commit)
    );
endmodule

// File: rtl/led_cmd_checker.sv
module led_cmd_checker #(
    parameter int NUM_CH = 24,
    parameter int DUTY_W = 7,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_valid,
    input logic              wr_all,
    input logic [CH_W-1:0]   wr_chan,
    input logic [DUTY_W-1:0] wr_duty,
    input logic              commit
);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    p_chan_range_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_all) |-> (wr_chan <= LAST_CH))
        else $error("channel index out of range");

    p_all_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        wr_all |-> wr_valid)
        else $error("broadcast flag without write strobe");

    p_write_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid)
        else $error("write strobe longer than one cycle");

    p_commit_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit)
        else $error("commit longer than one cycle");

    p_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
        !(wr_valid && commit))
        else $error("write and commit together");

    p_reset_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!wr_valid && !commit))
        else $error("activity right after reset");

    p_duty_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (!wr_valid && $past(!wr_valid)) |-> $stable(wr_duty))
        else $error("duty moved without a write");
endmodule

bind led_cmd_decoder led_cmd_checker #(.NUM_CH(NUM_CH), .DUTY_W(DUTY_W)) u_chk (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_all(wr_all),
    .wr_chan(wr_chan), .wr_duty(wr_duty), .commit(commit)
);

// File: tb/tb_led_cmd_decoder.sv
`timescale 1ns/1ps
module tb_led_cmd_decoder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_clk = 1'b0;
    logic       ser_dat = 1'b0;
    logic [5:0] local_id = 6'h05;   // matching address byte is 0x0A
    logic       wr_valid, wr_all, commit;
    logic [4:0] wr_chan;
    logic [6:0] wr_duty;

    always #2 clk = ~clk;   // 250 MHz

    led_cmd_decoder dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .local_id(local_id), .wr_valid(wr_valid), .wr_all(wr_all),
        .wr_chan(wr_chan), .wr_duty(wr_duty), .commit(commit)
    );

    int tests = 0, fails = 0, cycles = 0;
    int wr_cnt = 0, cmt_cnt = 0;
    logic [4:0] last_chan;
    logic [6:0] last_duty;
    logic       last_all;
    logic [6:0] shadow [0:23];

    // Port-side capture of strobes into a mirror of the downstream file.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst && wr_valid) begin
            wr_cnt    <= wr_cnt + 1;
            last_chan <= wr_chan;
            last_duty <= wr_duty;
            last_all  <= wr_all;
            if (wr_all) for (int i = 0; i < 24; i++) shadow[i] <= wr_duty;
            else        shadow[wr_chan] <= wr_duty;
        end
        if (!rst && commit) cmt_cnt <= cmt_cnt + 1;
    end

    always @(posedge clk) if (cycles > 150000) begin
        fails = fails + 1;
        $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic byte_rise(logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            ser_dat = b[i];
            tick(4);
            ser_clk = 1'b1;
            tick(4);
            if (i != 0) ser_clk = 1'b0;
        end
    endtask

    task automatic byte_fall();
        ser_clk = 1'b0;
        tick(12);
    endtask

    task automatic send(logic [7:0] b);
        byte_rise(b);
        byte_fall();
    endtask

    // {address, selector, data, expected channel, expected broadcast}
    localparam logic [39:0] VEC [0:5] = '{
        {8'h0A, 8'h02, 8'hFE, 8'd0,  8'd0},
        {8'h0A, 8'h30, 8'h02, 8'd23, 8'd0},
        {8'h01, 8'h1A, 8'hA4, 8'd12, 8'd0},
        {8'h7F, 8'h0E, 8'h54, 8'd6,  8'd0},
        {8'h0A, 8'h40, 8'h3C, 8'd0,  8'd1},
        {8'h0A, 8'h20, 8'h00, 8'd15, 8'd0}
    };

    int w0, c0;

    initial begin
        for (int i = 0; i < 24; i++) shadow[i] = '0;
        tick(5);
        check("R10 reset write", int'(wr_valid), 0);
        check("R10 reset commit", int'(commit), 0);
        rst = 1'b0;
        tick(5);

        // R2: bytes before any start byte are dropped
        send(8'h0A); send(8'h02); send(8'h7E); send(8'h81);
        check("R2 no write before start", wr_cnt, 0);
        check("R2 no commit before start", cmt_cnt, 0);

        // Table walk: R1 bit order, R3 address forms, R4 codes, R6, R9
        for (int v = 0; v < 6; v++) begin
            c0 = cmt_cnt;
            send(8'hFF); send(VEC[v][39:32]); send(VEC[v][31:24]);
            send(VEC[v][23:16]); send(8'h81);
            check("R4 channel", int'(last_chan), int'(VEC[v][15:8]) & (VEC[v][0] ? 0 : 31));
            check("R1 duty bits", int'(last_duty), int'(VEC[v][23:17]));
            check("R6 broadcast flag", int'(last_all), int'(VEC[v][0]));
            check("R9 commit", cmt_cnt, c0 + 1);
        end
        for (int i = 0; i < 24; i++)
            if (shadow[i] != 7'd30 && i != 15) check("R6 all channels", int'(shadow[i]), 30);
        check("R4 ch15 zero duty", int'(shadow[15]), 0);

        // R1: no strobe at the eighth rising edge, only after its fall
        send(8'hFF); send(8'h0A); send(8'h04);
        w0 = wr_cnt;
        byte_rise(8'h5A);
        tick(12);
        check("R1 held at 8th rise", wr_cnt, w0);
        byte_fall();
        check("R1 taken after 8th fall", wr_cnt, w0 + 1);
        check("R1 duty", int'(last_duty), 8'h5A >> 1);
        send(8'h81);

        // R3: wrong address ignored until next start
        w0 = wr_cnt; c0 = cmt_cnt;
        send(8'hFF); send(8'h0C); send(8'h02); send(8'h20); send(8'h81);
        check("R3 mismatch no write", wr_cnt, w0);
        check("R9 mismatch no commit", cmt_cnt, c0);

        // R2: start byte mid-packet restarts
        send(8'hFF); send(8'h0A); send(8'h02); send(8'hFF);
        send(8'h0A); send(8'h04); send(8'h14); send(8'h81);
        check("R2 restart ch0 kept", int'(shadow[0]), 30);
        check("R2 restart ch1", int'(shadow[1]), 10);

        // R5: several pairs in one packet
        w0 = wr_cnt; c0 = cmt_cnt;
        send(8'hFF); send(8'h0A); send(8'h06); send(8'h08);
        send(8'h08); send(8'h0C); send(8'h81);
        check("R5 two writes", wr_cnt, w0 + 2);
        check("R5 ch2", int'(shadow[2]), 4);
        check("R5 ch3", int'(shadow[3]), 6);
        check("R5 one commit", cmt_cnt, c0 + 1);

        // R7: sequential fill, capped at 24
        w0 = wr_cnt;
        send(8'hFF); send(8'h0A); send(8'h60);
        for (int k = 0; k < 26; k++) send(8'((k + 1) * 2));
        send(8'h81);
        check("R7 capped writes", wr_cnt, w0 + 24);
        check("R7 ch0", int'(shadow[0]), 1);
        check("R7 ch23", int'(shadow[23]), 24);

        // R7/R8: partial fill; selector-like codes act as data
        w0 = wr_cnt;
        send(8'hFF); send(8'h0A); send(8'h60);
        send(8'hC8); send(8'hC8); send(8'h02); send(8'h40); send(8'h81);
        check("R7 partial writes", wr_cnt, w0 + 4);
        check("R8 0x02 is data", int'(shadow[2]), 1);
        check("R8 0x40 is data", int'(shadow[3]), 32);
        check("R8 no broadcast", int'(last_all), 0);
        check("R7 ch4 kept", int'(shadow[4]), 5);

        // R10: reset mid-packet drops it
        w0 = wr_cnt; c0 = cmt_cnt;
        send(8'hFF); send(8'h0A); send(8'h02);
        @(negedge clk) rst = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(3);
        send(8'h7E); send(8'h81);
        check("R10 dropped write", wr_cnt, w0);
        check("R10 dropped commit", cmt_cnt, c0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule